// File: doc/BRIEF.md
# Single-Buffer Serial Channel Status and Interrupt Logic

This block holds the status flags, the two character registers and the interrupt outputs of an asynchronous serial channel that has exactly one transmit holding register and one receive holding register. A separate shifter moves the bits on the line. It tells this block that a character has finished through the strobes `tx_done` and `rx_done`, and it takes a new character when `tx_load` pulses. A host reads and writes four registers through a simple single-cycle port.

A status flag is cleared only by writing 0 to it after the host has read it as 1. A flag that is set after the host's last read survives the write. The parameter `ENHANCED` selects between two variants. In the basic variant, the host starts a transmission by clearing the empty flag through the status register, and the receive and transmit interrupts are levels. In the enhanced variant, a write to the transmit register starts the character, a read of the receive register releases the full flag, and the receive and transmit interrupts are single-cycle pulses.

Register addresses: 0 control, 1 status, 2 transmit data, 3 receive data. Control bits: bit0 transmitter on, bit1 receiver on, bit2 transmit-end interrupt enable, bit3 receive/error interrupt enable, bit4 transmit interrupt enable. Status bits: bit0 outgoing multiprocessor bit, bit1 received multiprocessor bit, bit2 transmit end (TEND), bit3 parity error (PER), bit4 framing error (FER), bit5 overrun (ORER), bit6 receive full (RDRF), bit7 transmit empty (TDRE).

Top module: `uart_sb_status`

## Requirements
- R1: After reset the status register reads 0x84, the control register reads 0, and all four interrupts and `tx_load` are low.
- R2: A status write clears a flag whose written bit is 0 only if the last status read returned that flag as 1. A written 1 leaves the flag unchanged, and a flag set after the last read survives.
- R3: Status bit0 takes the written value on every status write. Writes never change bits 1 and 2. In the enhanced variant, writes also never change bits 6 and 7.
- R4: A control write with bit0 set forces TDRE=1 and TEND=1.
- R5: In the enhanced variant, a transmit-data write with TEND=1 pulses `tx_load` for one cycle with `tx_byte` equal to the written value and leaves TDRE=1, TEND=0. With TEND=0, the write clears TDRE and does not load.
- R6: With the transmitter on, `tx_done` while TDRE=0 pulses `tx_load` with the held byte and sets TDRE=1, TEND=0. `tx_done` while TDRE=1 sets TEND.
- R7: In the basic variant, a status write that clears TDRE (read as 1, written 0) while no error flag remains set pulses `tx_load` and leaves TDRE=1, TEND=0. If an error flag remains set, TDRE stays 0 and nothing is loaded.
- R8: With the receiver on and RDRF=0, `rx_done` stores `rx_byte`, sets RDRF, ORs `rx_perr` and `rx_ferr` into PER and FER, and copies `rx_mpb` to bit1. With RDRF=1, `rx_done` sets ORER and keeps the held byte. With the receiver off, `rx_done` has no effect.
- R9: `rx_break` sets FER.
- R10: In the enhanced variant, reading the receive-data register clears RDRF. In the basic variant, the read leaves RDRF set.
- R11: `irq_err` is high exactly while control bit3 is set and any of PER, FER or ORER is set.
- R12: `irq_tend` is the level of (bit2 enable and TEND). In the basic variant, `irq_rx` is the level of (bit3 enable and RDRF) and `irq_tx` is the level of (bit4 enable and TDRE). In the enhanced variant, each of these is high for one cycle after its condition rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (side effects) |
| addr | input | 2 | Register select |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the selected register |
| tx_load | output | 1 | One-cycle request to the shifter to take `tx_byte` |
| tx_byte | output | CHAR_W | Held transmit character |
| tx_done | input | 1 | Shifter finished sending a character |
| rx_done | input | 1 | Shifter finished receiving a character |
| rx_byte | input | CHAR_W | Received character |
| rx_perr | input | 1 | Parity error on the received character |
| rx_ferr | input | 1 | Framing error on the received character |
| rx_mpb | input | 1 | Received multiprocessor bit |
| rx_break | input | 1 | Break detected on the line |
| irq_err | output | 1 | Error interrupt |
| irq_rx | output | 1 | Receive interrupt |
| irq_tx | output | 1 | Transmit interrupt |
| irq_tend | output | 1 | Transmit-end interrupt |

## Verification
The hardest state to reach is the one where every flag is set at once. A status write must then be judged against a read snapshot that holds overrun, both error flags and a full receiver, so that each written pattern decides both the clears and, in the basic variant, whether the empty-flag clear starts a transmission. The stimulus gets there by turning the transmitter and receiver on and sending two received characters back to back, the first with parity, framing and multiprocessor bits set. It then reads the status and sweeps all 256 write values on both variants, computing the expected register, load pulse and error interrupt in arithmetic.

// File: rtl/uart_sb_pkg.sv
// Shared constants and types for the single-buffer serial status block.
// Assumes an 8-bit host register width.
package uart_sb_pkg;
    localparam int REG_W  = 8;
    localparam int CTRL_W = 5;

    // Status bit positions
    localparam int B_MPBT = 0;
    localparam int B_MPB  = 1;
    localparam int B_TEND = 2;
    localparam int B_PER  = 3;
    localparam int B_FER  = 4;
    localparam int B_ORER = 5;
    localparam int B_RDRF = 6;
    localparam int B_TDRE = 7;

    localparam logic [REG_W-1:0] STAT_RESET = 8'h84;

    // Interrupt vector indices
    localparam int IRQ_ERR  = 0;
    localparam int IRQ_RX   = 1;
    localparam int IRQ_TX   = 2;
    localparam int IRQ_TEND = 3;
    localparam int IRQ_N    = 4;

    typedef enum logic [1:0] {
        A_CTRL = 2'd0,
        A_STAT = 2'd1,
        A_TXD  = 2'd2,
        A_RXD  = 2'd3
    } sb_addr_e;

    typedef struct packed {
        logic tie;
        logic rie;
        logic teie;
        logic rx_on;
        logic tx_on;
    } sb_ctrl_t;

    // Bits a status write can never clear
    function automatic logic [REG_W-1:0] wr_protect(input bit enh);
        return enh ? 8'hC7 : 8'h07;
    endfunction
endpackage

// File: rtl/sb_flags.sv
// Status flags and character holding registers.
// Applies, in order within one cycle: transmitter-on force, status write,
// transmit-data write, transmit completion, receive-data read, reception, break.
// Assumes CHAR_W <= 8 and at most one host access per cycle.
module sb_flags
    import uart_sb_pkg::*;
#(
    parameter bit ENHANCED = 1'b0,
    parameter int CHAR_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_on,
    input  logic              rx_on,
    input  logic              tx_force,
    input  logic              stat_we,
    input  logic              stat_re,
    input  logic              txd_we,
    input  logic              rxd_re,
    input  logic [REG_W-1:0]  wdata,
    input  logic              tx_done,
    input  logic              rx_done,
    input  logic [CHAR_W-1:0] rx_byte,
    input  logic              rx_perr,
    input  logic              rx_ferr,
    input  logic              rx_mpb,
    input  logic              rx_break,
    output logic [REG_W-1:0]  stat_q,
    output logic [REG_W-1:0]  stat_d,
    output logic [CHAR_W-1:0] tdr_q,
    output logic [CHAR_W-1:0] rdr_q,
    output logic              tx_load
);
    localparam logic [REG_W-1:0] PROT = wr_protect(ENHANCED);

    logic [REG_W-1:0]  snap_q, snap_d;
    logic [CHAR_W-1:0] tdr_d, rdr_d;
    logic              load_d;

    // Next-state of flags, holding registers and load request
    always_comb begin
        stat_d = stat_q;
        snap_d = snap_q;
        tdr_d  = tdr_q;
        rdr_d  = rdr_q;
        load_d = 1'b0;
        if (stat_re) snap_d = stat_q;
        if (tx_force) begin
            stat_d[B_TDRE] = 1'b1;
            stat_d[B_TEND] = 1'b1;
        end
        if (stat_we) begin
            for (int i = 0; i < REG_W; i++) begin
                if (!PROT[i] && snap_q[i] && !wdata[i]) stat_d[i] = 1'b0;
            end
            stat_d[B_MPBT] = wdata[B_MPBT];
            if (!ENHANCED && stat_q[B_TDRE] && !stat_d[B_TDRE]
                && (stat_d[B_ORER:B_PER] == '0)) begin
                load_d         = 1'b1;
                stat_d[B_TDRE] = 1'b1;
                stat_d[B_TEND] = 1'b0;
            end
        end
        if (txd_we) begin
            tdr_d = wdata[CHAR_W-1:0];
            if (ENHANCED) begin
                if (stat_d[B_TEND]) begin
                    load_d         = 1'b1;
                    stat_d[B_TDRE] = 1'b1;
                    stat_d[B_TEND] = 1'b0;
                end else begin
                    stat_d[B_TDRE] = 1'b0;
                end
            end
        end
        if (tx_done && tx_on) begin
            if (!stat_d[B_TDRE]) begin
                load_d         = 1'b1;
                stat_d[B_TDRE] = 1'b1;
                stat_d[B_TEND] = 1'b0;
            end else begin
                stat_d[B_TEND] = 1'b1;
            end
        end
        if (rxd_re && ENHANCED) stat_d[B_RDRF] = 1'b0;
        if (rx_done && rx_on) begin
            if (stat_d[B_RDRF]) begin
                stat_d[B_ORER] = 1'b1;
            end else begin
                stat_d[B_RDRF] = 1'b1;
                stat_d[B_PER]  = stat_d[B_PER] | rx_perr;
                stat_d[B_FER]  = stat_d[B_FER] | rx_ferr;
                stat_d[B_MPB]  = rx_mpb;
                rdr_d          = rx_byte;
            end
        end
        if (rx_break) stat_d[B_FER] = 1'b1;
    end

    // State registers with synchronous reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_q  <= STAT_RESET;
            snap_q  <= '0;
            tdr_q   <= '1;
            rdr_q   <= '0;
            tx_load <= 1'b0;
        end else begin
            stat_q  <= stat_d;
            snap_q  <= snap_d;
            tdr_q   <= tdr_d;
            rdr_q   <= rdr_d;
            tx_load <= load_d;
        end
    end
endmodule

// File: rtl/sb_irq_out.sv
// One interrupt output. Takes the next-cycle condition and produces either
// its registered level or a one-cycle pulse on its rising edge.
// Assumes cond_d is the condition as it will be after the coming edge.
module sb_irq_out #(
    parameter bit PULSE = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cond_d,
    output logic irq
);
    logic cond_q;

    // Registered copy of the condition
    always_ff @(posedge clk) begin
        if (!rst_n) cond_q <= 1'b0;
        else        cond_q <= cond_d;
    end

    generate
        if (PULSE) begin : g_pulse
            logic pls_q;
            // Pulse for one cycle when the condition rises
            always_ff @(posedge clk) begin
                if (!rst_n) pls_q <= 1'b0;
                else        pls_q <= cond_d & ~cond_q;
            end
            assign irq = pls_q;
        end else begin : g_level
            assign irq = cond_q;
        end
    endgenerate
endmodule

// File: rtl/uart_sb_status.sv
// Top: host register port, control register, flag core and interrupt outputs.
// Assumes single-cycle host accesses and CHAR_W <= 8.
module uart_sb_status
    import uart_sb_pkg::*;
#(
    parameter bit ENHANCED = 1'b0,
    parameter int CHAR_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [1:0]        addr,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata,
    output logic              tx_load,
    output logic [CHAR_W-1:0] tx_byte,
    input  logic              tx_done,
    input  logic              rx_done,
    input  logic [CHAR_W-1:0] rx_byte,
    input  logic              rx_perr,
    input  logic              rx_ferr,
    input  logic              rx_mpb,
    input  logic              rx_break,
    output logic              irq_err,
    output logic              irq_rx,
    output logic              irq_tx,
    output logic              irq_tend
);
    sb_addr_e         sel;
    sb_ctrl_t         ctrl_q, ctrl_d;
    logic [REG_W-1:0] stat_q, stat_d;
    logic [CHAR_W-1:0] rdr_q;
    logic [IRQ_N-1:0] cond_d, irq_vec;
    logic             ctrl_we;

    assign sel     = sb_addr_e'(addr);
    assign ctrl_we = wr_en && (sel == A_CTRL);

    // Control register next value
    always_comb ctrl_d = ctrl_we ? sb_ctrl_t'(wdata[CTRL_W-1:0]) : ctrl_q;

    // Control register
    always_ff @(posedge clk) begin
        if (!rst_n) ctrl_q <= '0;
        else        ctrl_q <= ctrl_d;
    end

    sb_flags #(.ENHANCED(ENHANCED), .CHAR_W(CHAR_W)) u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .tx_on    (ctrl_q.tx_on),
        .rx_on    (ctrl_q.rx_on),
        .tx_force (ctrl_we && wdata[0]),
        .stat_we  (wr_en && (sel == A_STAT)),
        .stat_re  (rd_en && (sel == A_STAT)),
        .txd_we   (wr_en && (sel == A_TXD)),
        .rxd_re   (rd_en && (sel == A_RXD)),
        .wdata    (wdata),
        .tx_done  (tx_done),
        .rx_done  (rx_done),
        .rx_byte  (rx_byte),
        .rx_perr  (rx_perr),
        .rx_ferr  (rx_ferr),
        .rx_mpb   (rx_mpb),
        .rx_break (rx_break),
        .stat_q   (stat_q),
        .stat_d   (stat_d),
        .tdr_q    (tx_byte),
        .rdr_q    (rdr_q),
        .tx_load  (tx_load)
    );

    // Interrupt conditions as they will stand after the coming edge
    always_comb begin
        cond_d[IRQ_ERR]  = ctrl_d.rie  && (stat_d[B_ORER:B_PER] != '0);
        cond_d[IRQ_RX]   = ctrl_d.rie  && stat_d[B_RDRF];
        cond_d[IRQ_TX]   = ctrl_d.tie  && stat_d[B_TDRE];
        cond_d[IRQ_TEND] = ctrl_d.teie && stat_d[B_TEND];
    end

    generate
        for (genvar g = 0; g < IRQ_N; g++) begin : g_irq
            sb_irq_out #(.PULSE(ENHANCED && (g == IRQ_RX || g == IRQ_TX))) u_irq (
                .clk    (clk),
                .rst_n  (rst_n),
                .cond_d (cond_d[g]),
                .irq    (irq_vec[g])
            );
        end
    endgenerate

    assign irq_err  = irq_vec[IRQ_ERR];
    assign irq_rx   = irq_vec[IRQ_RX];
    assign irq_tx   = irq_vec[IRQ_TX];
    assign irq_tend = irq_vec[IRQ_TEND];

    // Read data multiplexer
    always_comb begin
        case (sel)
            A_CTRL:  rdata = REG_W'(ctrl_q);
            A_STAT:  rdata = stat_q;
            A_TXD:   rdata = REG_W'(tx_byte);
            default: rdata = REG_W'(rdr_q);
        endcase
    end
endmodule

// File: rtl/sb_status_chk.sv
// Property checker for uart_sb_status, attached by bind.
module sb_status_chk #(
    parameter bit ENHANCED = 1'b0
) (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en,
    input logic       rd_en,
    input logic [1:0] addr,
    input logic [7:0] wdata,
    input logic       rx_done,
    input logic [7:0] stat,
    input logic [4:0] ctrl,
    input logic       tx_load,
    input logic       irq_err,
    input logic       irq_rx,
    input logic       irq_tend
);
    p_txon_forces_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 2'd0 && wdata[0]) |=> (stat[7] && stat[2]));

    p_overrun_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_done && ctrl[1] && stat[6] && !(ENHANCED && rd_en && addr == 2'd3))
        |=> stat[5]);

    p_load_state_r6: assert property (@(posedge clk) disable iff (!rst_n)
        tx_load |-> (stat[7] && !stat[2]));

    p_err_level_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl[3] && stat[5:3] != 3'b000) |-> irq_err);

    p_tend_level_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl[2] && stat[2]) |-> irq_tend);

    p_rx_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (ENHANCED && irq_rx) |=> !irq_rx);

    p_ro_bit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 2'd1 && !rx_done) |=> (stat[1] == $past(stat[1])));
endmodule

bind uart_sb_status sb_status_chk #(.ENHANCED(ENHANCED)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .rd_en    (rd_en),
    .addr     (addr),
    .wdata    (wdata),
    .rx_done  (rx_done),
    .stat     (stat_q),
    .ctrl     (ctrl_q),
    .tx_load  (tx_load),
    .irq_err  (irq_err),
    .irq_rx   (irq_rx),
    .irq_tend (irq_tend)
);

// File: tb/sim_uart_sb_status.sv
// Bench: u0 is the basic variant, u1 the enhanced variant.
module sim_uart_sb_status;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic       wr_en[2], rd_en[2], tx_done[2], rx_done[2];
    logic       rx_perr[2], rx_ferr[2], rx_mpb[2], rx_break[2];
    logic [1:0] addr[2];
    logic [7:0] wdata[2], rx_byte[2], rdata[2], tx_byte[2];
    logic       tx_load[2], irq_err[2], irq_rx[2], irq_tx[2], irq_tend[2];

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    uart_sb_status #(.ENHANCED(1'b0), .CHAR_W(8)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en[0]), .rd_en(rd_en[0]), .addr(addr[0]),
        .wdata(wdata[0]), .rdata(rdata[0]), .tx_load(tx_load[0]), .tx_byte(tx_byte[0]),
        .tx_done(tx_done[0]), .rx_done(rx_done[0]), .rx_byte(rx_byte[0]),
        .rx_perr(rx_perr[0]), .rx_ferr(rx_ferr[0]), .rx_mpb(rx_mpb[0]), .rx_break(rx_break[0]),
        .irq_err(irq_err[0]), .irq_rx(irq_rx[0]), .irq_tx(irq_tx[0]), .irq_tend(irq_tend[0]));

    uart_sb_status #(.ENHANCED(1'b1), .CHAR_W(8)) u1 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en[1]), .rd_en(rd_en[1]), .addr(addr[1]),
        .wdata(wdata[1]), .rdata(rdata[1]), .tx_load(tx_load[1]), .tx_byte(tx_byte[1]),
        .tx_done(tx_done[1]), .rx_done(rx_done[1]), .rx_byte(rx_byte[1]),
        .rx_perr(rx_perr[1]), .rx_ferr(rx_ferr[1]), .rx_mpb(rx_mpb[1]), .rx_break(rx_break[1]),
        .irq_err(irq_err[1]), .irq_rx(irq_rx[1]), .irq_tx(irq_tx[1]), .irq_tend(irq_tend[1]));

    task automatic chk(input string req, input int v, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s variant=%0d actual=0x%02h expected=0x%02h", req, v, act, exp);
        end
    endtask

    task automatic idle_all();
        for (int v = 0; v < 2; v++) begin
            wr_en[v] = 0; rd_en[v] = 0; tx_done[v] = 0; rx_done[v] = 0;
            rx_perr[v] = 0; rx_ferr[v] = 0; rx_mpb[v] = 0; rx_break[v] = 0;
            addr[v] = 0; wdata[v] = 0; rx_byte[v] = 0;
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 0; idle_all();
        @(negedge clk); @(negedge clk); rst_n = 1;
    endtask

    task automatic wr(input int v, input logic [1:0] a, input logic [7:0] d);
        wr_en[v] = 1; addr[v] = a; wdata[v] = d;
        @(negedge clk); wr_en[v] = 0;
    endtask

    task automatic rd(input int v, input logic [1:0] a, output logic [7:0] d);
        rd_en[v] = 1; addr[v] = a; #1; d = rdata[v];
        @(negedge clk); rd_en[v] = 0;
    endtask

    task automatic rx(input int v, input logic [7:0] b, input logic pe, input logic fe, input logic mp);
        rx_done[v] = 1; rx_byte[v] = b; rx_perr[v] = pe; rx_ferr[v] = fe; rx_mpb[v] = mp;
        @(negedge clk); rx_done[v] = 0; rx_perr[v] = 0; rx_ferr[v] = 0; rx_mpb[v] = 0;
    endtask

    task automatic txd(input int v);
        tx_done[v] = 1; @(negedge clk); tx_done[v] = 0;
    endtask

    task automatic brk(input int v);
        rx_break[v] = 1; @(negedge clk); rx_break[v] = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog all actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] s, e, d;
        logic       ld;
        idle_all();
        do_reset();

        // R1 reset state
        for (int v = 0; v < 2; v++) begin
            rd(v, 2'd1, s); chk("R1 status", v, s, 8'h84);
            rd(v, 2'd0, s); chk("R1 control", v, s, 8'h00);
            chk("R1 irqs", v, {3'b0, tx_load[v], irq_err[v], irq_rx[v], irq_tx[v], irq_tend[v]}, 8'h00);
        end

        // R2 R3 R7 R11 sweep of every status write value from the all-flags state
        for (int w = 0; w < 256; w++) begin
            for (int v = 0; v < 2; v++) begin
                do_reset();
                wr(v, 2'd0, 8'h0B);
                rx(v, 8'h11, 1, 1, 1);
                rx(v, 8'h22, 0, 0, 0);
                rd(v, 2'd1, s); chk("R8 all flags", v, s, 8'hFE);
                wr(v, 2'd1, w[7:0]);
                e = 8'hFE; e[0] = w[0]; ld = 0;
                for (int i = 3; i < 8; i++)
                    if (!(v == 1 && i >= 6) && !w[i]) e[i] = 0;
                if (v == 0 && !w[7] && e[5:3] == 3'b000) begin
                    ld = 1; e[7] = 1; e[2] = 0;
                end
                chk("R7 load", v, {7'b0, tx_load[v]}, {7'b0, ld});
                chk("R11 err irq", v, {7'b0, irq_err[v]}, {7'b0, |e[5:3]});
                rd(v, 2'd1, s); chk("R2 R3 status", v, s, e);
            end
        end

        // R2 flag set after the read survives (basic)
        do_reset();
        wr(0, 2'd0, 8'h03);
        rd(0, 2'd1, s);
        rx(0, 8'h3C, 0, 0, 0);
        wr(0, 2'd1, 8'h80);
        rd(0, 2'd1, s); chk("R2 unread survives", 0, s, 8'hC4);
        wr(0, 2'd1, 8'h80);
        rd(0, 2'd1, s); chk("R2 read then cleared", 0, s, 8'h84);

        // R8 receiver off ignored, overrun keeps held byte
        do_reset();
        rx(0, 8'h55, 1, 1, 1);
        rd(0, 2'd1, s); chk("R8 rx off", 0, s, 8'h84);
        wr(0, 2'd0, 8'h02);
        rx(0, 8'h66, 0, 0, 0);
        rx(0, 8'h77, 0, 0, 0);
        rd(0, 2'd3, d); chk("R8 held byte", 0, d, 8'h66);
        rd(0, 2'd1, s); chk("R8 overrun", 0, s, 8'hE4);
        chk("R10 basic rdrf kept", 0, {7'b0, s[6]}, 8'h01);

        // R10 enhanced read clears full flag; R12 pulsed rx irq
        do_reset();
        wr(1, 2'd0, 8'h0A);
        rx(1, 8'h99, 0, 0, 0);
        chk("R12 rx pulse high", 1, {7'b0, irq_rx[1]}, 8'h01);
        @(negedge clk);
        chk("R12 rx pulse ends", 1, {7'b0, irq_rx[1]}, 8'h00);
        rd(1, 2'd3, d); chk("R10 data", 1, d, 8'h99);
        rd(1, 2'd1, s); chk("R10 enhanced clear", 1, s, 8'h84);

        // R12 basic level rx irq persists
        do_reset();
        wr(0, 2'd0, 8'h0A);
        rx(0, 8'h10, 0, 0, 0);
        @(negedge clk); @(negedge clk);
        chk("R12 rx level", 0, {7'b0, irq_rx[0]}, 8'h01);

        // R4 R5 R6 R12 enhanced transmit sequence
        do_reset();
        wr(1, 2'd0, 8'h15);
        rd(1, 2'd1, s); chk("R4 force", 1, s & 8'h84, 8'h84);
        chk("R12 tend level", 1, {7'b0, irq_tend[1]}, 8'h01);
        wr(1, 2'd2, 8'h5A);
        chk("R5 immediate load", 1, {7'b0, tx_load[1]}, 8'h01);
        chk("R5 byte", 1, tx_byte[1], 8'h5A);
        rd(1, 2'd1, s); chk("R5 status", 1, s, 8'h80);
        wr(1, 2'd2, 8'h33);
        chk("R5 no load", 1, {7'b0, tx_load[1]}, 8'h00);
        rd(1, 2'd1, s); chk("R5 tdre cleared", 1, s, 8'h00);
        txd(1);
        chk("R6 next load", 1, {7'b0, tx_load[1]}, 8'h01);
        chk("R6 next byte", 1, tx_byte[1], 8'h33);
        chk("R12 tx pulse", 1, {7'b0, irq_tx[1]}, 8'h01);
        @(negedge clk);
        chk("R12 tx pulse ends", 1, {7'b0, irq_tx[1]}, 8'h00);
        rd(1, 2'd1, s); chk("R6 status", 1, s, 8'h80);
        txd(1);
        rd(1, 2'd1, s); chk("R6 end", 1, s, 8'h84);
        chk("R12 tend irq", 1, {7'b0, irq_tend[1]}, 8'h01);

        // R7 R9 basic start blocked by framing error from break
        do_reset();
        wr(0, 2'd0, 8'h11);
        wr(0, 2'd2, 8'hA5);
        chk("R7 txd write no load", 0, {7'b0, tx_load[0]}, 8'h00);
        chk("R12 tx level", 0, {7'b0, irq_tx[0]}, 8'h01);
        brk(0);
        rd(0, 2'd1, s); chk("R9 break", 0, s, 8'h94);
        wr(0, 2'd1, 8'h10);
        chk("R7 blocked", 0, {7'b0, tx_load[0]}, 8'h00);
        rd(0, 2'd1, s); chk("R7 blocked status", 0, s, 8'h14);
        // clear FER, then restart by clearing TDRE
        wr(0, 2'd1, 8'h00);
        wr(0, 2'd0, 8'h01);
        rd(0, 2'd1, s);
        wr(0, 2'd1, 8'h7F);
        chk("R7 start load", 0, {7'b0, tx_load[0]}, 8'h01);
        chk("R7 start byte", 0, tx_byte[0], 8'hA5);
        rd(0, 2'd1, s); chk("R7 start status", 0, s, 8'h81);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule